// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block guards the entry of new thread blocks onto one multiprocessor. It holds four pools: warp slots, 32-bit registers, shared-memory bytes and resident-block slots. A request arrives with a thread count, a register count per thread, a shared-memory byte count for the whole block and a kernel identifier. From these the block works out what the request needs and compares each need with the free amount in its pool. When every need fits and the kernel identifier is acceptable, the block grants the request in the same cycle, assigns it the lowest free block slot and records what it took.

A request that cannot be admitted yet is held at the head. The source keeps `req_valid` high, `req_wait` is asserted, and nothing behind it can pass. Requests are therefore served strictly in order. A finished block is reported by a one-cycle completion pulse that carries its slot number. The amounts recorded for that slot go back to the pools at the next clock edge. A waiting request is evaluated again against the new counts in the following cycle. A request with an out-of-range thread count is consumed with an error pulse and allocates nothing.

The number of blocks that can be resident at once is the smallest of the limits set by the four pools. An admitted block keeps its slot until its own completion pulse arrives.

Top module: `adm_ctl`

## Requirements
- R1: A request needs ceil(threads / 32) warp slots; a partial last warp takes a whole slot. A grant lowers `free_warps` by that amount at the next edge, and the pool holds 64 warp slots.
- R2: A request needs registers-per-thread × threads registers, taken from a 65536-entry pool, and its stated shared-memory bytes, taken from a 65536-byte pool. A grant lowers both free counts by these amounts.
- R3: `req_grant` is high in a cycle where `req_valid` is high only if warps, registers, shared memory and a block slot all fit. Otherwise `req_wait` is high, no pool changes, and the request stays at the head. At most one of `req_grant`, `req_error` and `req_wait` is high in any cycle.
- R4: There are 16 block slots. A grant assigns the lowest-numbered free slot on `req_slot`, and a request waits while all 16 are occupied.
- R5: While any block is resident, a request whose `req_kernel` differs from the kernel of the resident blocks waits. When no block is resident, any kernel may be admitted.
- R6: A `done_valid` pulse naming an occupied slot returns that slot's recorded warps, registers and bytes, and frees the slot. The new counts appear on the free outputs after the edge, and a waiting request can be granted in the next cycle.
- R7: A request with 0 threads or more than 1024 threads gets `req_error` in the same cycle, is consumed, and changes no free count.
- R8: A `done_valid` pulse naming an unoccupied slot changes no free count.
- R9: After reset, the free counts read 64 warps, 65536 registers, 65536 bytes and 16 slots, and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present; held high until granted or rejected |
| req_threads | input | 11 | Threads per block |
| req_regs_per_thread | input | 8 | 32-bit registers per thread |
| req_smem | input | 17 | Shared-memory bytes per block |
| req_kernel | input | 8 | Kernel identifier |
| req_grant | output | 1 | Request admitted this cycle |
| req_error | output | 1 | Request rejected as malformed this cycle |
| req_wait | output | 1 | Request valid but held for resources or kernel |
| req_slot | output | 4 | Slot assigned to a granted request |
| done_valid | input | 1 | Completion pulse |
| done_slot | input | 4 | Slot of the completed block |
| free_warps | output | 7 | Free warp slots |
| free_regs | output | 17 | Free registers |
| free_smem | output | 17 | Free shared-memory bytes |
| free_slots | output | 5 | Free block slots |

## Verification
The assertions assume that the request fields stay stable while `req_valid` is high and that `done_valid` lasts one cycle and names a real slot number. The stimulus changes inputs only at falling edges and pulses each completion for a single cycle. It withdraws a waiting request only after the cycle in which the wait is observed, and it never sends a completion for a slot that is granted in that same cycle.

// File: rtl/adm_pkg.sv
package adm_pkg;
  // Warp slots consumed by a block: a partial trailing warp still costs a slot.
  function automatic int adm_warps_for(input int threads, input int warp_size);
    return (threads + warp_size - 1) / warp_size;
  endfunction

  // Registers consumed by a block.
  function automatic int adm_regs_for(input int threads, input int regs_per_thread);
    return threads * regs_per_thread;
  endfunction

  // A thread count that can be admitted at all.
  function automatic bit adm_threads_ok(input int threads, input int max_threads);
    return (threads != 0) && (threads <= max_threads);
  endfunction
endpackage

// File: rtl/adm_demand.sv
module adm_demand
  import adm_pkg::*;
#(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 1024,
  parameter int TW          = 11,
  parameter int RPT_W       = 8,
  parameter int WARP_CW     = 7,
  parameter int REG_DW      = 19
) (
  input  logic [TW-1:0]      threads,
  input  logic [RPT_W-1:0]   regs_per_thread,
  output logic [WARP_CW-1:0] need_warps,
  output logic [REG_DW-1:0]  need_regs,
  output logic               malformed
);
  always_comb begin
    need_warps = WARP_CW'(adm_warps_for(int'(threads), WARP_SIZE));
    need_regs  = REG_DW'(adm_regs_for(int'(threads), int'(regs_per_thread)));
    malformed  = !adm_threads_ok(int'(threads), MAX_THREADS);
  end
endmodule

// File: rtl/adm_slot_table.sv
module adm_slot_table #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4,
  parameter int WARP_CW   = 7,
  parameter int REG_CW    = 17,
  parameter int SMEM_CW   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [WARP_CW-1:0] alloc_warps,
  input  logic [REG_CW-1:0]  alloc_regs,
  input  logic [SMEM_CW-1:0] alloc_smem,
  input  logic               done_valid,
  input  logic [SLOT_W-1:0]  done_slot,
  output logic [SLOT_W-1:0]  free_idx,
  output logic               any_free,
  output logic               ret_valid,
  output logic [WARP_CW-1:0] ret_warps,
  output logic [REG_CW-1:0]  ret_regs,
  output logic [SMEM_CW-1:0] ret_smem
);
  logic [NUM_SLOTS-1:0] occ;
  logic [WARP_CW-1:0]   rec_w [NUM_SLOTS];
  logic [REG_CW-1:0]    rec_r [NUM_SLOTS];
  logic [SMEM_CW-1:0]   rec_s [NUM_SLOTS];

  // Lowest free slot wins.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_idx = SLOT_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign ret_valid = done_valid && occ[done_slot];
  assign ret_warps = rec_w[done_slot];
  assign ret_regs  = rec_r[done_slot];
  assign ret_smem  = rec_s[done_slot];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic               v_q;
    logic [WARP_CW-1:0] w_q;
    logic [REG_CW-1:0]  r_q;
    logic [SMEM_CW-1:0] s_q;
    logic               take;
    logic               give;
    assign take = alloc && any_free && (free_idx == SLOT_W'(g));
    assign give = ret_valid && (done_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        w_q <= '0;
        r_q <= '0;
        s_q <= '0;
      end else if (take) begin
        v_q <= 1'b1;
        w_q <= alloc_warps;
        r_q <= alloc_regs;
        s_q <= alloc_smem;
      end else if (give) begin
        v_q <= 1'b0;
      end
    end
    assign occ[g]   = v_q;
    assign rec_w[g] = w_q;
    assign rec_r[g] = r_q;
    assign rec_s[g] = s_q;
  end
endmodule

// File: rtl/adm_ctl.sv
module adm_ctl #(
  parameter int WARP_SIZE   = 32,
  parameter int MAX_WARPS   = 64,
  parameter int NUM_SLOTS   = 16,
  parameter int REG_FILE    = 65536,
  parameter int SMEM_BYTES  = 65536,
  parameter int MAX_THREADS = 1024,
  parameter int TW          = 11,
  parameter int RPT_W       = 8,
  parameter int KID_W       = 8,
  parameter int WARP_CW     = $clog2(MAX_WARPS + 1),
  parameter int REG_CW      = $clog2(REG_FILE + 1),
  parameter int SMEM_CW     = $clog2(SMEM_BYTES + 1),
  parameter int SLOT_W      = $clog2(NUM_SLOTS),
  parameter int SLOT_CW     = $clog2(NUM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [TW-1:0]      req_threads,
  input  logic [RPT_W-1:0]   req_regs_per_thread,
  input  logic [SMEM_CW-1:0] req_smem,
  input  logic [KID_W-1:0]   req_kernel,
  output logic               req_grant,
  output logic               req_error,
  output logic               req_wait,
  output logic [SLOT_W-1:0]  req_slot,
  input  logic               done_valid,
  input  logic [SLOT_W-1:0]  done_slot,
  output logic [WARP_CW-1:0] free_warps,
  output logic [REG_CW-1:0]  free_regs,
  output logic [SMEM_CW-1:0] free_smem,
  output logic [SLOT_CW-1:0] free_slots
);
  localparam int REG_DW = TW + RPT_W;

  logic [WARP_CW-1:0] need_warps;
  logic [REG_DW-1:0]  need_regs;
  logic               malformed;
  logic               any_free;
  logic               ret_valid;
  logic [WARP_CW-1:0] ret_warps;
  logic [REG_CW-1:0]  ret_regs;
  logic [SMEM_CW-1:0] ret_smem;
  logic [KID_W-1:0]   cur_kernel;
  logic               fit_warps, fit_regs, fit_smem, kernel_ok, all_fit;

  adm_demand #(
    .WARP_SIZE(WARP_SIZE), .MAX_THREADS(MAX_THREADS), .TW(TW),
    .RPT_W(RPT_W), .WARP_CW(WARP_CW), .REG_DW(REG_DW)
  ) u_demand (
    .threads(req_threads), .regs_per_thread(req_regs_per_thread),
    .need_warps(need_warps), .need_regs(need_regs), .malformed(malformed)
  );

  adm_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WARP_CW(WARP_CW),
    .REG_CW(REG_CW), .SMEM_CW(SMEM_CW)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc(req_grant),
    .alloc_warps(need_warps), .alloc_regs(REG_CW'(need_regs)), .alloc_smem(req_smem),
    .done_valid(done_valid), .done_slot(done_slot),
    .free_idx(req_slot), .any_free(any_free),
    .ret_valid(ret_valid), .ret_warps(ret_warps), .ret_regs(ret_regs), .ret_smem(ret_smem)
  );

  // Admission decision: every pool must fit at once.
  assign fit_warps = need_warps <= free_warps;
  assign fit_regs  = need_regs <= REG_DW'(free_regs);
  assign fit_smem  = req_smem <= free_smem;
  assign kernel_ok = (free_slots == SLOT_CW'(NUM_SLOTS)) || (req_kernel == cur_kernel);
  assign all_fit   = fit_warps && fit_regs && fit_smem && any_free && kernel_ok;

  assign req_error = req_valid && malformed;
  assign req_grant = req_valid && !malformed && all_fit;
  assign req_wait  = req_valid && !malformed && !all_fit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_warps <= WARP_CW'(MAX_WARPS);
      free_regs  <= REG_CW'(REG_FILE);
      free_smem  <= SMEM_CW'(SMEM_BYTES);
      free_slots <= SLOT_CW'(NUM_SLOTS);
      cur_kernel <= '0;
    end else begin
      free_warps <= free_warps - (req_grant ? need_warps : '0) + (ret_valid ? ret_warps : '0);
      free_regs  <= free_regs - (req_grant ? REG_CW'(need_regs) : '0) + (ret_valid ? ret_regs : '0);
      free_smem  <= free_smem - (req_grant ? req_smem : '0) + (ret_valid ? ret_smem : '0);
      free_slots <= free_slots - SLOT_CW'(req_grant) + SLOT_CW'(ret_valid);
      if (req_grant) cur_kernel <= req_kernel;
    end
  end

  // Pool never exceeds its capacity.
  assert_warp_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    free_warps <= WARP_CW'(MAX_WARPS));
  assert_reg_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    free_regs <= REG_CW'(REG_FILE));
  assert_outcome_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_grant, req_error, req_wait}));
  assert_wait_holds_pools_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_wait && !ret_valid |=> $stable(free_warps) && $stable(free_regs) && $stable(free_smem));
  assert_grant_takes_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant && !ret_valid |=> free_slots == $past(free_slots) - SLOT_CW'(1));
  assert_same_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant && free_slots != SLOT_CW'(NUM_SLOTS) |-> req_kernel == cur_kernel);
  assert_return_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !req_grant |=> free_slots == $past(free_slots) + SLOT_CW'(1));
  assert_error_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_error && !ret_valid |=> $stable(free_warps) && $stable(free_slots) && $stable(free_regs));
  assert_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !ret_valid && !req_grant |=> $stable(free_slots) && $stable(free_warps));
endmodule

// File: tb/adm_ctl_tb.sv
`timescale 1ns/1ps
module adm_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [10:0] req_threads = '0;
  logic [7:0]  req_regs_per_thread = '0;
  logic [16:0] req_smem = '0;
  logic [7:0]  req_kernel = '0;
  logic        req_grant, req_error, req_wait;
  logic [3:0]  req_slot;
  logic        done_valid = 1'b0;
  logic [3:0]  done_slot = '0;
  logic [6:0]  free_warps;
  logic [16:0] free_regs, free_smem;
  logic [4:0]  free_slots;

  always #2.5 clk = ~clk;

  adm_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_regs_per_thread(req_regs_per_thread), .req_smem(req_smem), .req_kernel(req_kernel),
    .req_grant(req_grant), .req_error(req_error), .req_wait(req_wait), .req_slot(req_slot),
    .done_valid(done_valid), .done_slot(done_slot), .free_warps(free_warps),
    .free_regs(free_regs), .free_smem(free_smem), .free_slots(free_slots)
  );

  int checks = 0;
  int fails  = 0;

  // Bench's own pool model.
  int m_w = 64, m_r = 65536, m_s = 65536, m_n = 16;
  int rec_w [16], rec_r [16], rec_s [16];
  bit occ [16];

  // Outcome codes: 0 grant, 1 error, 2 wait.
  // Entry: {threads[37:27], regs_per_thread[26:19], smem[18:2], outcome[1:0]}
  localparam logic [37:0] VEC [0:8] = '{
    {11'd48,   8'd32, 17'd1000,  2'd0},  // R1 partial warp: 2 warps
    {11'd1024, 8'd32, 17'd32768, 2'd0},  // R2 half of regs and smem
    {11'd0,    8'd4,  17'd0,     2'd1},  // R7 zero threads
    {11'd1025, 8'd1,  17'd0,     2'd1},  // R7 too many threads
    {11'd1024, 8'd32, 17'd0,     2'd2},  // R3 warps short (needs 32, 30 free)
    {11'd900,  8'd16, 17'd32768, 2'd2},  // R3 smem short
    {11'd900,  8'd40, 17'd0,     2'd2},  // R3 regs short
    {11'd33,   8'd1,  17'd31768, 2'd0},  // R2 smem exactly fills
    {11'd1,    8'd0,  17'd0,     2'd0}   // R1 single thread still one warp
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < 16; i++) if (!occ[i]) return i;
    return -1;
  endfunction

  task automatic check_pools(input string tag);
    chk(free_warps == m_w, {tag, " free_warps"}, free_warps, m_w);
    chk(free_regs  == m_r, {tag, " free_regs"},  free_regs,  m_r);
    chk(free_smem  == m_s, {tag, " free_smem"},  free_smem,  m_s);
    chk(free_slots == m_n, {tag, " free_slots"}, free_slots, m_n);
  endtask

  task automatic try_req(input int thr, input int rpt, input int sm, input int kid,
                         input int code, input string tag);
    int slot;
    @(negedge clk);
    req_valid = 1'b1; req_threads = 11'(thr); req_regs_per_thread = 8'(rpt);
    req_smem = 17'(sm); req_kernel = 8'(kid);
    #1;
    chk(req_grant == (code == 0), {tag, " grant"}, req_grant, code == 0);
    chk(req_error == (code == 1), {tag, " error"}, req_error, code == 1);
    chk(req_wait  == (code == 2), {tag, " wait"},  req_wait,  code == 2);
    slot = low_free();
    if (code == 0) chk(req_slot == 4'(slot), {tag, " slot"}, req_slot, slot);
    @(negedge clk);
    req_valid = 1'b0;
    if (code == 0) begin
      occ[slot] = 1'b1;
      rec_w[slot] = (thr + 31) / 32; rec_r[slot] = thr * rpt; rec_s[slot] = sm;
      m_w -= rec_w[slot]; m_r -= rec_r[slot]; m_s -= sm; m_n -= 1;
    end
    #1;
    check_pools(tag);
  endtask

  task automatic done(input int slot, input string tag);
    @(negedge clk);
    done_valid = 1'b1; done_slot = 4'(slot);
    @(negedge clk);
    done_valid = 1'b0;
    if (occ[slot]) begin
      occ[slot] = 1'b0;
      m_w += rec_w[slot]; m_r += rec_r[slot]; m_s += rec_s[slot]; m_n += 1;
    end
    #1;
    check_pools(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) occ[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_pools("R9 reset");
    chk(req_grant == 1'b0, "R9 no grant", req_grant, 0);

    for (int v = 0; v < 9; v++)
      try_req(int'(VEC[v][37:27]), int'(VEC[v][26:19]), int'(VEC[v][18:2]), 1,
              int'(VEC[v][1:0]), $sformatf("R3 vector %0d", v));

    // R4: fill remaining slots, then the seventeenth block waits.
    for (int i = 0; i < 12; i++) try_req(1, 0, 0, 1, 0, "R4 fill");
    try_req(1, 0, 0, 1, 2, "R4 slots full");

    // R6: completion while a request waits; grant in the following cycle.
    @(negedge clk);
    req_valid = 1'b1; req_threads = 11'd64; req_regs_per_thread = 8'd0;
    req_smem = 17'd0; req_kernel = 8'd1;
    done_valid = 1'b1; done_slot = 4'd5;
    #1;
    chk(req_wait == 1'b1, "R6 still waiting in done cycle", req_wait, 1);
    @(negedge clk);
    done_valid = 1'b0;
    #1;
    chk(req_grant == 1'b1, "R6 grant after return", req_grant, 1);
    chk(req_slot == 4'd5, "R6 reused slot", req_slot, 5);
    @(negedge clk);
    req_valid = 1'b0;
    m_w = m_w + 1 - 2; rec_w[5] = 2; rec_r[5] = 0; rec_s[5] = 0;
    #1;
    check_pools("R6 after regrant");

    // R5: another kernel waits while blocks are resident.
    try_req(1, 0, 0, 2, 2, "R5 foreign kernel");

    for (int i = 0; i < 16; i++) done(i, "R6 drain");
    check_pools("R6 all returned");
    done(3, "R8 stray completion");

    try_req(1, 0, 0, 2, 0, "R5 new kernel on empty");
    try_req(1024, 64, 0, 2, 0, "R2 whole register file");
    try_req(1, 1, 0, 2, 2, "R3 regs exhausted");
    try_req(32, 0, 65536, 3, 2, "R5 kernel mismatch with room");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule